// File: doc/BRIEF.md
# Registered Dual-Product Sum Unit

This block forms the sum of two 8-bit by 8-bit unsigned products, S = A·B + C·D. It returns a 16-bit result and a carry bit that holds the 17th bit of that sum. All four operands arrive over one shared pair of byte inputs. A pair-select input decides which operand bank the bytes are written into: bank AB holds A and B, bank CD holds C and D. A write enable decides whether anything is written at all.

Each operand sits in its own register. Two multipliers and one adder sit between the operand registers and a registered result. Because of this, the arithmetic is a single register-to-register path, and the result follows the operands one clock later. Two monitor outputs show the operand bytes of whichever bank the pair-select input points at. All registers clear through an active-low asynchronous reset.

Top module: `dual_product_sum`

## Requirements
- R1: While `rst_n` is 0, every operand register, `sum_q` and `carry_q` read 0. This takes effect at once, without waiting for a clock edge, so `mon_hi` and `mon_lo` also read 0.
- R2: With `wr_en` = 1 at a rising edge, `pair_sel` = 0 loads A from `byte_hi` and B from `byte_lo`. `pair_sel` = 1 loads C from `byte_hi` and D from `byte_lo`.
- R3: With `wr_en` = 0 at a rising edge, no operand register changes.
- R4: The bank that `pair_sel` does not point at keeps its value while the other bank loads.
- R5: `mon_hi` shows A when `pair_sel` = 0 and C when `pair_sel` = 1. `mon_lo` shows B or D in the same way. Both follow the current `pair_sel` with no clock delay.
- R6: `{carry_q, sum_q}` equals the 17-bit sum of A·B and C·D. Each product is taken as an unsigned 16-bit value, and `carry_q` is bit 16 of the sum.
- R7: The result register captures on every rising edge. An operand captured at edge k shows in `sum_q`/`carry_q` after edge k+1, and not before.
- R8: With all four operands at 255, `sum_q` = 0xFC02 and `carry_q` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | 1 = write the input bytes into the selected bank |
| pair_sel | input | 1 | 0 = bank AB, 1 = bank CD |
| byte_hi | input | 8 | Left operand byte (A or C) |
| byte_lo | input | 8 | Right operand byte (B or D) |
| mon_hi | output | 8 | A or C, according to `pair_sel` |
| mon_lo | output | 8 | B or D, according to `pair_sel` |
| sum_q | output | 16 | Registered low 16 bits of A·B + C·D |
| carry_q | output | 1 | Registered bit 16 of A·B + C·D |

## Verification
Two things happen on the same edge: an operand bank is written, and the result register captures the sum built from the operands as they stood before that edge. The bench provokes this by holding `wr_en` high over two consecutive edges. The first edge writes bank AB and the second writes bank CD. After the second edge, the bench expects a mixed result: the new A·B plus the old C·D. Only after the third edge does it expect the full new sum. A design that adds a register stage or drops one fails this mixed check. So does a design whose result bypasses the operand registers.

// File: rtl/sumprod_pkg.sv
// Shared sizes and types for the dual-product sum unit.
// Assumes unsigned operands; all widths derive from OP_W.
package sumprod_pkg;
    parameter int OP_W   = 8;
    parameter int N_BANK = 2;
    localparam int PROD_W = 2 * OP_W;
    localparam int SUM_W  = PROD_W + 1;

    // Bank index as driven on pair_sel.
    typedef enum logic {
        BANK_AB = 1'b0,
        BANK_CD = 1'b1
    } bank_e;

    // One operand bank: left byte (A or C), right byte (B or D).
    typedef struct packed {
        logic [OP_W-1:0] lft;
        logic [OP_W-1:0] rgt;
    } opnd_pair_t;
endpackage

// File: rtl/operand_bank.sv
// Holds one operand pair. It loads both bytes together when its load strobe is high.
// Assumes the strobe is already qualified by write enable and bank select.
module operand_bank
    import sumprod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  opnd_pair_t din,
    output opnd_pair_t q
);
    // Operand storage: clear on reset, capture on strobe, otherwise hold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/product_unit.sv
// Unsigned multiply of one operand pair, full-width product, purely combinational.
// Assumes the caller registers both its inputs and its output.
module product_unit
    import sumprod_pkg::*;
(
    input  opnd_pair_t        pair,
    output logic [PROD_W-1:0] prod
);
    // Widen both operands before multiplying so no product bit is lost.
    always_comb begin
        prod = PROD_W'(pair.lft) * PROD_W'(pair.rgt);
    end
endmodule

// File: rtl/sum_stage.sv
// Adds the per-bank products and registers the low bits plus a carry.
// Assumes one product per bank; the result register updates on every edge.
module sum_stage
    import sumprod_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_BANK*PROD_W-1:0] prods,
    output logic [PROD_W-1:0]        sum_q,
    output logic                     carry_q
);
    logic [SUM_W-1:0] total;

    // Widened sum across all banks; the top bit becomes the carry.
    always_comb begin
        total = '0;
        for (int i = 0; i < N_BANK; i++) begin
            total = total + SUM_W'(prods[i*PROD_W +: PROD_W]);
        end
    end

    // Result register: clear on reset, capture the fresh sum each edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            sum_q   <= total[PROD_W-1:0];
            carry_q <= total[SUM_W-1];
        end
    end
endmodule

// File: rtl/dual_product_sum.sv
// Top level: a shared byte input feeds two operand banks.
// The banks drive two multipliers and one adder into a registered result.
// Assumes pair_sel and wr_en are synchronous to clk.
module dual_product_sum
    import sumprod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              pair_sel,
    input  logic [OP_W-1:0]   byte_hi,
    input  logic [OP_W-1:0]   byte_lo,
    output logic [OP_W-1:0]   mon_hi,
    output logic [OP_W-1:0]   mon_lo,
    output logic [PROD_W-1:0] sum_q,
    output logic              carry_q
);
    opnd_pair_t                in_pair;
    opnd_pair_t                bank_q [N_BANK];
    logic [N_BANK*PROD_W-1:0]  prods;
    opnd_pair_t                pair_ab_q;
    opnd_pair_t                pair_cd_q;

    // Bundle the shared input bytes into one pair.
    always_comb begin
        in_pair.lft = byte_hi;
        in_pair.rgt = byte_lo;
    end

    // One bank and one multiplier per operand pair.
    for (genvar g = 0; g < N_BANK; g++) begin : g_bank
        logic load_g;

        // This bank loads only when it is the write target.
        always_comb begin
            load_g = wr_en && (pair_sel == 1'(g));
        end

        operand_bank i_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load_g),
            .din   (in_pair),
            .q     (bank_q[g])
        );

        product_unit i_mul (
            .pair (bank_q[g]),
            .prod (prods[g*PROD_W +: PROD_W])
        );
    end

    sum_stage i_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .prods   (prods),
        .sum_q   (sum_q),
        .carry_q (carry_q)
    );

    // Named views of the two banks, for the monitors and the checker.
    always_comb begin
        pair_ab_q = bank_q[BANK_AB];
        pair_cd_q = bank_q[BANK_CD];
    end

    // Monitor mux: show the bank that pair_sel currently points at.
    always_comb begin
        if (pair_sel == BANK_CD) begin
            mon_hi = pair_cd_q.lft;
            mon_lo = pair_cd_q.rgt;
        end else begin
            mon_hi = pair_ab_q.lft;
            mon_lo = pair_ab_q.rgt;
        end
    end
endmodule

// File: rtl/sumprod_checker.sv
// Protocol checker for dual_product_sum, attached through bind.
// Assumes bank AB is index 0 and bank CD is index 1.
module sumprod_checker
    import sumprod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              pair_sel,
    input  logic [OP_W-1:0]   byte_hi,
    input  logic [OP_W-1:0]   byte_lo,
    input  opnd_pair_t        pair_ab,
    input  opnd_pair_t        pair_cd,
    input  logic [OP_W-1:0]   mon_hi,
    input  logic [OP_W-1:0]   mon_lo,
    input  logic [PROD_W-1:0] sum_q,
    input  logic              carry_q
);
    logic [SUM_W-1:0] ref_sum;

    // Independent reference sum built from the current operand registers.
    always_comb begin
        ref_sum = SUM_W'(pair_ab.lft) * SUM_W'(pair_ab.rgt)
                + SUM_W'(pair_cd.lft) * SUM_W'(pair_cd.rgt);
    end

    assert_load_ab_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pair_sel) |=> (pair_ab.lft == $past(byte_hi) && pair_ab.rgt == $past(byte_lo)));

    assert_load_cd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pair_sel) |=> (pair_cd.lft == $past(byte_hi) && pair_cd.rgt == $past(byte_lo)));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pair_ab) && $stable(pair_cd)));

    assert_other_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pair_sel) |=> $stable(pair_cd));

    assert_monitor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((pair_sel != $past(pair_sel)) ||
                   (mon_hi == $past(byte_hi) && mon_lo == $past(byte_lo))));

    assert_result_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({carry_q, sum_q} == $past(ref_sum)));
endmodule

bind dual_product_sum sumprod_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .pair_sel (pair_sel),
    .byte_hi  (byte_hi),
    .byte_lo  (byte_lo),
    .pair_ab  (pair_ab_q),
    .pair_cd  (pair_cd_q),
    .mon_hi   (mon_hi),
    .mon_lo   (mon_lo),
    .sum_q    (sum_q),
    .carry_q  (carry_q)
);

// File: tb/test_dual_product_sum.sv
// Directed bench for dual_product_sum: one task per scenario, each checking itself.
module test_dual_product_sum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        pair_sel = 1'b0;
    logic [7:0]  byte_hi = '0;
    logic [7:0]  byte_lo = '0;
    logic [7:0]  mon_hi, mon_lo;
    logic [15:0] sum_q;
    logic        carry_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int mA = 0, mB = 0, mC = 0, mD = 0;

    always #5 clk = ~clk;

    dual_product_sum i_dual_product_sum (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pair_sel(pair_sel),
        .byte_hi(byte_hi), .byte_lo(byte_lo), .mon_hi(mon_hi), .mon_lo(mon_lo),
        .sum_q(sum_q), .carry_q(carry_q)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Expected 17-bit sum from the bench's own operand model.
    function automatic int model_sum();
        return mA * mB + mC * mD;
    endfunction

    // Compare the result outputs against the model.
    task automatic chk_result(input string req);
        chk(req, {15'd0, carry_q, sum_q}, model_sum());
    endtask

    // Write one bank: drive at a negedge, capture on the next posedge, leave at a negedge.
    task automatic write_bank(input logic sel, input int hi, input int lo);
        @(negedge clk);
        wr_en = 1'b1; pair_sel = sel; byte_hi = 8'(hi); byte_lo = 8'(lo);
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) begin mC = hi; mD = lo; end else begin mA = hi; mB = lo; end
    endtask

    // Let the result register take one more edge.
    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R1 sum at reset", int'(sum_q), 0);
        chk("R1 carry at reset", int'(carry_q), 0);
        chk("R1 mon_hi at reset", int'(mon_hi), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_basic();
        write_bank(1'b0, 12, 34);
        chk("R5 mon_hi shows A", int'(mon_hi), 12);
        chk("R5 mon_lo shows B", int'(mon_lo), 34);
        settle();
        chk_result("R6 A*B only");
        write_bank(1'b1, 200, 3);
        chk("R2 mon_hi shows C", int'(mon_hi), 200);
        settle();
        chk_result("R6 A*B + C*D");
        pair_sel = 1'b0; #1;
        chk("R5 mon_hi follows sel to A", int'(mon_hi), 12);
        chk("R5 mon_lo follows sel to B", int'(mon_lo), 34);
        pair_sel = 1'b1; #1;
        chk("R4 C kept while A loaded", int'(mon_hi), 200);
    endtask

    task automatic t_max();
        write_bank(1'b0, 255, 255);
        write_bank(1'b1, 255, 255);
        settle();
        chk("R8 sum all 255", int'(sum_q), 16'hFC02);
        chk("R8 carry all 255", int'(carry_q), 1);
    endtask

    task automatic t_wr_low();
        @(negedge clk);
        wr_en = 1'b0; pair_sel = 1'b0; byte_hi = 8'd7; byte_lo = 8'd9;
        repeat (3) @(negedge clk);
        chk("R3 A unchanged with wr_en low", int'(mon_hi), mA);
        chk("R3 B unchanged with wr_en low", int'(mon_lo), mB);
        pair_sel = 1'b1; @(negedge clk);
        chk("R3 C unchanged with wr_en low", int'(mon_hi), mC);
        chk_result("R3 result unchanged with wr_en low");
    endtask

    // Back-to-back writes: a bank load coincides with the result capture.
    task automatic t_overlap();
        int oldC, oldD;
        oldC = mC; oldD = mD;
        @(negedge clk);
        wr_en = 1'b1; pair_sel = 1'b0; byte_hi = 8'd3; byte_lo = 8'd5;
        @(negedge clk);
        mA = 3; mB = 5;
        chk("R7 result not yet updated after capture edge", {15'd0, carry_q, sum_q}, 255 * 255 + oldC * oldD);
        pair_sel = 1'b1; byte_hi = 8'd10; byte_lo = 8'd11;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 mixed new A*B plus old C*D", {15'd0, carry_q, sum_q}, 15 + oldC * oldD);
        mC = 10; mD = 11;
        settle();
        chk_result("R7 full new sum one edge later");
    endtask

    task automatic t_random();
        for (int i = 0; i < 40; i++) begin
            write_bank(1'($urandom), int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
            settle();
            chk_result("R6 random operands");
        end
    endtask

    task automatic t_reset_mid();
        write_bank(1'b0, 77, 88);
        settle();
        #2 rst_n = 1'b0;
        #1;
        chk("R1 async sum clear", int'(sum_q), 0);
        chk("R1 async carry clear", int'(carry_q), 0);
        chk("R1 async monitor clear", int'(mon_hi), 0);
        @(negedge clk);
        rst_n = 1'b1;
        mA = 0; mB = 0; mC = 0; mD = 0;
        write_bank(1'b1, 9, 9);
        settle();
        chk_result("R1 bank AB cleared by reset");
    endtask

    initial begin
        t_reset_state();
        t_basic();
        t_max();
        t_wr_low();
        t_overlap();
        t_random();
        t_reset_mid();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule